// File: doc/BRIEF.md
# Converter Fault Supervisor with Two-Class Restart

This block decides whether a two-output switching converter may run. It collects reference health, input-voltage limits, an enable pin of selectable polarity and two output-undervoltage flags. From these it drives a single `run` level that gates both PWM channels. Every asynchronous input passes through a synchroniser before the logic uses it.

Two kinds of fault exist, and they recover differently. An ordinary fault (reference lost, input under- or overvoltage, shutdown request) drops `run` at once. Once the fault has gone, `run` comes back on its own as soon as the soft-start capacitor reports discharged (`ss_low`). A sustained output undervoltage is timed by a tick-driven counter. If the counter expires, the block latches `ouv_fault`. Recovery from that state has two steps: both output flags must first go low together, and then the enable pin or the input-undervoltage line must complete a deassert/reassert cycle whose reassert edge arrives while `ss_low` is true.

Top module: `conv_fault_supervisor`

## Requirements
- R1: While `rst_n` is low at a clock edge, `run` and `ouv_fault` are 0 and `timer_count` is 0 after that edge.
- R2: A shutdown request exists when `en_pol`=1 and `enable`=1, or when `en_pol`=0 and `enable`=0; it holds `run` low.
- R3: `ref_good`=0, `vin_uv`=1 or `vin_ov`=1 each force `run` low; run is low in the cycle after the synchronised fault is seen.
- R4: `run` rises only at an edge where the synchronised `ss_low` is 1; after an ordinary fault clears, `run` stays low until then.
- R5: `timer_count` increments by one per `tick` while either output flag is high, saturates at `TERM`, and returns to 0 in any cycle where both flags are low.
- R6: When a tick takes the count to `TERM`, `ouv_fault` is set and `run` goes low; `run` is never high while `ouv_fault` is 1.
- R7: `ouv_fault` clears only at an edge where both synchronised output flags are low.
- R8: After an expiry, `run` stays low until `ouv_fault` has cleared and an enable toggle (enable good, then not good, then good again) completes. Its final edge must be seen while `ss_low`=1 and `ouv_fault` is already 0. A toggle that ends with `ss_low`=0, or in the same cycle that `ouv_fault` clears, does not count.
- R9: The same restart is also accepted from a toggle of `vin_uv` (high, then low).
- R10: The level inputs reach the logic through `SYNC_STAGES` (default 2) flip-flops. `tick` is used directly. A fault driven before edge k lowers `run` at edge k+`SYNC_STAGES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timer advance strobe, synchronous to clk |
| ref_good | input | 1 | Reference voltage healthy |
| vin_uv | input | 1 | Input undervoltage detected |
| vin_ov | input | 1 | Input overvoltage detected |
| enable | input | 1 | Enable pin, polarity set by en_pol |
| en_pol | input | 1 | 1: enable active low; 0: enable active high |
| oflag_main | input | 1 | Main output undervoltage flag |
| oflag_aux | input | 1 | Auxiliary output undervoltage flag |
| ss_low | input | 1 | Soft start discharged below restart level |
| run | output | 1 | Permission for both PWM channels |
| ouv_fault | output | 1 | Latched output-undervoltage timeout |
| timer_count | output | $clog2(TERM+1) | Undervoltage timer value |

## Verification
The hardest coincidence is the end of an enable toggle arriving through the synchroniser in the same cycle as both output flags going low. In that case `ouv_fault` clears on the very edge that sees the reassert, so the toggle must not be counted. The bench provokes this by releasing the flags and restoring `enable` on one clock, after `enable` has already been dropped. A behavioural reference model, updated on every edge, predicts `run` as staying low. A full toggle afterwards must then bring `run` back.

// File: rtl/cfs_pkg.sv
// Shared definitions for the converter fault supervisor.
// Assumes: all fields are single-bit level signals sampled by one clock.
package cfs_pkg;

    // Bundle of the asynchronous level inputs, in synchroniser order.
    typedef struct packed {
        logic ref_good;
        logic vin_uv;
        logic vin_ov;
        logic enable;
        logic en_pol;
        logic oflag_main;
        logic oflag_aux;
        logic ss_low;
    } cfs_in_t;

    localparam int IN_W = $bits(cfs_in_t);

    // Shutdown request: active-low enable when pol=1, active-high when pol=0.
    function automatic logic shutdown_req(input logic pol, input logic en);
        return pol ? en : ~en;
    endfunction

endpackage

// File: rtl/cfs_sync.sv
// Multi-bit level synchroniser: each bit passes through STAGES flip-flops.
// Assumes: bits are independent quasi-static levels (no bus coherency needed).
module cfs_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain;

    // Shift the sampled vector down the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/cfs_ouv_timer.sv
// Output-undervoltage delay timer. Counts ticks while either flag is high,
// saturates at TERM, and clears in any cycle with both flags low.
// Emits a one-cycle expire pulse on the tick that reaches TERM.
// Assumes: TERM >= 1; tick is synchronous to clk.
module cfs_ouv_timer #(
    parameter int TERM = 8,
    parameter int CW   = $clog2(TERM + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          flag_main,
    input  logic          flag_aux,
    output logic [CW-1:0] count,
    output logic          any_flag,
    output logic          expire
);
    localparam logic [CW-1:0] LAST = CW'(TERM - 1);
    localparam logic [CW-1:0] TOP  = CW'(TERM);

    assign any_flag = flag_main | flag_aux;
    assign expire   = tick & any_flag & (count == LAST);

    // Advance, hold at terminal, or restart from zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (!any_flag) begin
            count <= '0;
        end else if (tick && count != TOP) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/cfs_restart.sv
// Run latch and restart arbiter. Ordinary faults block run until they clear
// and ss_low is seen. A timer expiry latches ouv_fault and a restart lock;
// the lock opens on a full toggle of enable-good or uv-good whose final
// edge is seen with ss_low high and ouv_fault already clear.
// Assumes: all inputs are synchronised to clk.
module cfs_restart (
    input  logic clk,
    input  logic rst_n,
    input  logic ord_fault,
    input  logic en_good,
    input  logic uv_good,
    input  logic ss_ok,
    input  logic expire,
    input  logic flags_low,
    output logic run,
    output logic ouv_fault
);
    logic lock_q;
    logic en_dn_q, uv_dn_q;
    logic en_prev_q, uv_prev_q;
    logic en_rise, en_fall, uv_rise, uv_fall;
    logic unlock, blocked;

    assign en_rise = en_good & ~en_prev_q;
    assign en_fall = ~en_good & en_prev_q;
    assign uv_rise = uv_good & ~uv_prev_q;
    assign uv_fall = ~uv_good & uv_prev_q;

    assign unlock  = lock_q & ~ouv_fault & ss_ok &
                     ((en_rise & en_dn_q) | (uv_rise & uv_dn_q));
    assign blocked = ord_fault | ouv_fault | lock_q | expire;

    // Remember last level of each toggle source for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_prev_q <= 1'b0;
            uv_prev_q <= 1'b0;
        end else begin
            en_prev_q <= en_good;
            uv_prev_q <= uv_good;
        end
    end

    // Latch the timeout fault; release once both flags are low together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ouv_fault <= 1'b0;
        end else if (expire) begin
            ouv_fault <= 1'b1;
        end else if (ouv_fault && flags_low) begin
            ouv_fault <= 1'b0;
        end
    end

    // Restart lock set by expiry, opened by a qualified toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (expire) begin
            lock_q <= 1'b1;
        end else if (unlock) begin
            lock_q <= 1'b0;
        end
    end

    // Track the deassert half of a toggle for each source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_dn_q <= 1'b0;
            uv_dn_q <= 1'b0;
        end else if (expire) begin
            en_dn_q <= 1'b0;
            uv_dn_q <= 1'b0;
        end else begin
            if (lock_q && en_fall)  en_dn_q <= 1'b1;
            else if (en_rise)       en_dn_q <= 1'b0;
            if (lock_q && uv_fall)  uv_dn_q <= 1'b1;
            else if (uv_rise)       uv_dn_q <= 1'b0;
        end
    end

    // Run latch: cleared by any block, set when soft start is discharged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
        end else if (blocked) begin
            run <= 1'b0;
        end else if (ss_ok) begin
            run <= 1'b1;
        end
    end
endmodule

// File: rtl/conv_fault_supervisor.sv
// Top of the converter fault supervisor. Synchronises the level inputs,
// forms the ordinary fault, runs the undervoltage timer and the restart
// arbiter. Assumes: tick is a clk-synchronous strobe; other inputs async.
module conv_fault_supervisor #(
    parameter int TERM        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic                       ref_good,
    input  logic                       vin_uv,
    input  logic                       vin_ov,
    input  logic                       enable,
    input  logic                       en_pol,
    input  logic                       oflag_main,
    input  logic                       oflag_aux,
    input  logic                       ss_low,
    output logic                       run,
    output logic                       ouv_fault,
    output logic [$clog2(TERM+1)-1:0]  timer_count
);
    import cfs_pkg::*;

    localparam int CW = $clog2(TERM + 1);

    cfs_in_t raw_in, s_in;
    logic    shut, ord_fault, en_good, uv_good, flags_low;
    logic    any_flag, expire, ss_s;

    assign raw_in = '{ref_good: ref_good, vin_uv: vin_uv, vin_ov: vin_ov,
                      enable: enable, en_pol: en_pol, oflag_main: oflag_main,
                      oflag_aux: oflag_aux, ss_low: ss_low};

    cfs_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (s_in)
    );

    assign shut      = shutdown_req(s_in.en_pol, s_in.enable);
    assign en_good   = ~shut;
    assign uv_good   = ~s_in.vin_uv;
    assign ord_fault = ~s_in.ref_good | s_in.vin_uv | s_in.vin_ov | shut;
    assign flags_low = ~s_in.oflag_main & ~s_in.oflag_aux;
    assign ss_s      = s_in.ss_low;

    cfs_ouv_timer #(.TERM(TERM), .CW(CW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .flag_main(s_in.oflag_main),
        .flag_aux (s_in.oflag_aux),
        .count    (timer_count),
        .any_flag (any_flag),
        .expire   (expire)
    );

    cfs_restart restart_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ord_fault(ord_fault),
        .en_good  (en_good),
        .uv_good  (uv_good),
        .ss_ok    (ss_s),
        .expire   (expire),
        .flags_low(flags_low),
        .run      (run),
        .ouv_fault(ouv_fault)
    );
endmodule

// File: rtl/cfs_checker.sv
// Property checker for conv_fault_supervisor, attached with bind.
// Assumes: signals are those of the top and its synchronised internals.
module cfs_checker #(
    parameter int TERM = 8,
    parameter int CW   = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          run,
    input logic          ouv_fault,
    input logic [CW-1:0] timer_count,
    input logic          ord_fault,
    input logic          any_flag,
    input logic          flags_low,
    input logic          ss_s
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!run && !ouv_fault && timer_count == '0));

    assert_fault_drops_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ord_fault |=> !run);

    assert_rise_needs_ss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(ss_s));

    assert_timer_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        timer_count <= CW'(TERM));

    assert_timer_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && any_flag && timer_count < CW'(TERM)) |=>
            timer_count == $past(timer_count) + 1'b1);

    assert_ouv_blocks_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ouv_fault |-> !run);

    assert_clear_needs_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ouv_fault) |-> $past(flags_low));
endmodule

bind conv_fault_supervisor cfs_checker #(.TERM(TERM), .CW(CW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .run        (run),
    .ouv_fault  (ouv_fault),
    .timer_count(timer_count),
    .ord_fault  (ord_fault),
    .any_flag   (any_flag),
    .flags_low  (flags_low),
    .ss_s       (ss_s)
);

// File: tb/conv_fault_supervisor_tb_top.sv
// Bench: behavioural reference model compared on every clock, plus
// directed checks per requirement.
module conv_fault_supervisor_tb_top;
    localparam int TERM   = 8;
    localparam int STAGES = 2;
    localparam int CW     = $clog2(TERM + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic ref_good = 1'b1, vin_uv = 1'b0, vin_ov = 1'b0;
    logic enable = 1'b1, en_pol = 1'b0;
    logic oflag_main = 1'b0, oflag_aux = 1'b0, ss_low = 1'b0;
    logic tick_on = 1'b0;
    logic run, ouv_fault;
    logic [CW-1:0] timer_count;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;   // 250 MHz

    conv_fault_supervisor #(.TERM(TERM), .SYNC_STAGES(STAGES)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ref_good(ref_good),
        .vin_uv(vin_uv), .vin_ov(vin_ov), .enable(enable), .en_pol(en_pol),
        .oflag_main(oflag_main), .oflag_aux(oflag_aux), .ss_low(ss_low),
        .run(run), .ouv_fault(ouv_fault), .timer_count(timer_count)
    );

    // ---------------- reference model ----------------
    bit [7:0] hist[$];
    bit m_run, m_f, m_lock, m_edn, m_udn, m_ep, m_up;
    int m_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            for (int i = 0; i < STAGES; i++) hist.push_back(8'h00);
            m_run = 0; m_f = 0; m_lock = 0; m_edn = 0; m_udn = 0;
            m_ep = 0; m_up = 0; m_cnt = 0;
        end else begin
            bit [7:0] s;
            bit shut, flt, eg, ug, anyf, exp_p, er, ef, ur, uf, unl;
            s = hist.pop_front();
            hist.push_back({ref_good, vin_uv, vin_ov, enable, en_pol,
                            oflag_main, oflag_aux, ss_low});
            shut  = s[3] ? s[4] : !s[4];
            flt   = !s[7] || s[6] || s[5] || shut;
            eg    = !shut;
            ug    = !s[6];
            anyf  = s[2] || s[1];
            exp_p = tick && anyf && (m_cnt == TERM - 1);
            er = eg && !m_ep; ef = !eg && m_ep;
            ur = ug && !m_up; uf = !ug && m_up;
            unl = m_lock && !m_f && s[0] && ((er && m_edn) || (ur && m_udn));
            if (flt || m_f || m_lock || exp_p) m_run = 0;
            else if (s[0]) m_run = 1;
            if (exp_p) begin m_edn = 0; m_udn = 0; end
            else begin
                if (m_lock && ef) m_edn = 1; else if (er) m_edn = 0;
                if (m_lock && uf) m_udn = 1; else if (ur) m_udn = 0;
            end
            if (exp_p) m_lock = 1; else if (unl) m_lock = 0;
            if (exp_p) m_f = 1; else if (m_f && !anyf) m_f = 0;
            if (!anyf) m_cnt = 0;
            else if (tick && m_cnt < TERM) m_cnt = m_cnt + 1;
            m_ep = eg; m_up = ug;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 run vs model", int'(run), int'(m_run));
            chk("R6 ouv_fault vs model", int'(ouv_fault), int'(m_f));
            chk("R5 timer vs model", int'(timer_count), m_cnt);
        end
    end

    // Tick strobe every second cycle when enabled.
    always @(negedge clk) tick <= tick_on && !tick;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic expire_main;
        oflag_main = 1'b1;
        step(2 * TERM + 8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        done = 1;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        step(4);
        chk("R1 run in reset", int'(run), 0);
        chk("R1 ouv_fault in reset", int'(ouv_fault), 0);
        chk("R1 timer in reset", int'(timer_count), 0);
        rst_n = 1'b1;

        // R4: no run without ss_low
        step(10);
        chk("R4 run waits for ss_low", int'(run), 0);
        ss_low = 1'b1; step(5);
        chk("R4 run after ss_low", int'(run), 1);
        ss_low = 1'b0;

        // R10: latency through synchroniser
        step(2);
        ref_good = 1'b0; step(2);
        chk("R10 run still high before sync", int'(run), 1);
        step(1);
        chk("R10 run low after sync", int'(run), 0);
        ref_good = 1'b1; step(6);
        chk("R4 no auto restart without ss_low", int'(run), 0);
        ss_low = 1'b1; step(5);
        chk("R3 recover after ref_good", int'(run), 1);

        // R3: uv and ov
        vin_uv = 1'b1; step(5);
        chk("R3 vin_uv drops run", int'(run), 0);
        vin_uv = 1'b0; step(5);
        chk("R3 recover after vin_uv", int'(run), 1);
        vin_ov = 1'b1; step(5);
        chk("R3 vin_ov drops run", int'(run), 0);
        vin_ov = 1'b0; step(5);
        chk("R3 recover after vin_ov", int'(run), 1);

        // R2: polarity of enable
        en_pol = 1'b1; step(5);
        chk("R2 pol=1 enable=1 shuts down", int'(run), 0);
        enable = 1'b0; step(5);
        chk("R2 pol=1 enable=0 runs", int'(run), 1);
        en_pol = 1'b0; step(5);
        chk("R2 pol=0 enable=0 shuts down", int'(run), 0);
        enable = 1'b1; step(5);
        chk("R2 pol=0 enable=1 runs", int'(run), 1);

        // R5: timer count and clear
        tick_on = 1'b1;
        oflag_main = 1'b1; step(8);
        chk("R5 timer advancing", int'(timer_count > 0), 1);
        chk("R5 run kept before expiry", int'(run), 1);
        oflag_main = 1'b0; step(4);
        chk("R5 timer cleared", int'(timer_count), 0);

        // R6: expiry via aux flag
        oflag_aux = 1'b1; step(2 * TERM + 8);
        chk("R6 ouv_fault latched", int'(ouv_fault), 1);
        chk("R6 run low on expiry", int'(run), 0);
        chk("R5 timer saturated", int'(timer_count), TERM);

        // R7: hand-over between flags keeps the fault
        oflag_main = 1'b1; oflag_aux = 1'b0; step(10);
        chk("R7 fault held with one flag high", int'(ouv_fault), 1);
        oflag_main = 1'b0; step(5);
        chk("R7 fault cleared with both low", int'(ouv_fault), 0);
        chk("R8 no restart without toggle", int'(run), 0);

        // R8: toggle without ss_low ignored, then valid toggle
        ss_low = 1'b0;
        enable = 1'b0; step(5); enable = 1'b1; step(5);
        ss_low = 1'b1; step(5);
        chk("R8 toggle without ss_low ignored", int'(run), 0);
        enable = 1'b0; step(5); enable = 1'b1; step(6);
        chk("R8 restart after qualified toggle", int'(run), 1);

        // R9: restart via vin_uv toggle
        expire_main();
        chk("R6 second expiry", int'(ouv_fault), 1);
        oflag_main = 1'b0; step(5);
        vin_uv = 1'b1; step(5); vin_uv = 1'b0; step(6);
        chk("R9 restart after uv toggle", int'(run), 1);

        // R8 corner: toggle end coincides with fault clearing
        expire_main();
        enable = 1'b0; step(5);
        oflag_main = 1'b0; enable = 1'b1; step(10);
        chk("R8 coincident clear not a restart", int'(run), 0);
        chk("R7 fault cleared at coincidence", int'(ouv_fault), 0);
        enable = 1'b0; step(5); enable = 1'b1; step(6);
        chk("R8 restart after later toggle", int'(run), 1);

        // R1: reset mid-run
        rst_n = 1'b0; step(2);
        chk("R1 run after reset", int'(run), 0);
        chk("R1 timer after reset", int'(timer_count), 0);
        done = 1;
        report();
    end
endmodule